// File: doc/BRIEF.md
# Message Buffer Reconfiguration Guard

This block keeps the configuration of a small set of message buffers in a time-triggered bus controller and checks every host request that would change one of them. Each buffer entry stores a direction bit (receive or transmit) and a type bit (single or double). A double transmit buffer takes up an aligned pair of entries. The even entry of the pair is the commit half and the odd entry is the transmit half. The buffer handling logic reports the live state of every buffer on an input vector. Each buffer is disabled, disabled-and-locked, or active.

Each request is sorted by which type bits it would change. If the single/double bit changes, the request is a split or merge class. If only the direction bit changes, it is a direction-change class. If neither bit changes, it is a same-type class. The request is accepted only when the buffer states allow its class. A rejected request leaves every entry untouched and returns a reason code. A separate request kind writes a common configuration word. That write is accepted only while the protocol reports its configuration state. The outcome of every request is returned as a one-cycle pulse on the cycle after it was presented.

Top module: `mbr_guard`

## Requirements
- R1: After reset every entry reads single receive (`buf_dir_o`=0, `buf_dbl_o`=0), `cfg_o` is zero and neither response pulse is high.
- R2: A request sampled with `req_valid_i` high gives exactly one of `rsp_acc_o`/`rsp_rej_o` high for the following cycle. With no request, both stay low.
- R3: A single buffer request that changes no type bit, or changes only the direction bit, is accepted when the buffer state is disabled (code 0) or disabled-and-locked (code 1). In the active state (code 2 or 3) it is rejected with reason 1 (state). An accepted direction change stores the new direction.
- R4: A direction-only change aimed at either half of a double buffer is rejected with reason 2 (class not applicable), whatever the states.
- R5: A request that changes no type bit on a double buffer is accepted only when both halves of the pair are in state 0. Otherwise it is rejected with reason 1.
- R6: A request that changes the single/double bit is accepted only when both entries of the pair (index with bit 0 cleared, and that index plus one) are in state 0. A locked or active state gives reason 1.
- R7: A merge (single to double) must be requested on an even index. An odd index is rejected with reason 3 (pair), and this check takes priority over the state check. An accepted merge sets both entries of the pair to double transmit, whatever `req_dir_i` says.
- R8: A split (double to single), requested on either half, sets both entries of the pair to single with direction `req_dir_i`.
- R9: A request with `req_common_i` high stores `req_cfg_i` into `cfg_o` only when `proto_cfg_i` is high. Otherwise it is rejected with reason 4 (protocol) and `cfg_o` is unchanged. Such a request never changes a buffer entry.
- R10: A rejected request changes no entry and no common value. An accepted split or merge updates both entries of the pair on the same clock edge as the response.
- R11: The two entries of any aligned pair always agree on the type bit, and every double entry reads transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| proto_cfg_i | input | 1 | High while the protocol is in its configuration state |
| buf_state_i | input | 2*NUM_BUF | State of buffer n at bits [2n+1:2n]: 0 disabled, 1 disabled-and-locked, 2/3 active |
| req_valid_i | input | 1 | Request strobe, one cycle per request |
| req_common_i | input | 1 | Request writes the common configuration word instead of a buffer entry |
| req_idx_i | input | log2(NUM_BUF) | Target buffer index |
| req_dir_i | input | 1 | Requested direction, 1 = transmit |
| req_dbl_i | input | 1 | Requested type, 1 = double |
| req_cfg_i | input | CFG_W | Common configuration data |
| rsp_acc_o | output | 1 | Accept pulse, one cycle after the request |
| rsp_rej_o | output | 1 | Reject pulse, one cycle after the request |
| rsp_code_o | output | 3 | Reason: 0 ok, 1 state, 2 not applicable, 3 pair, 4 protocol |
| buf_dir_o | output | NUM_BUF | Stored direction bit per entry |
| buf_dbl_o | output | NUM_BUF | Stored type bit per entry |
| cfg_o | output | CFG_W | Stored common configuration word |

## Verification
The bench aims at the places where the three classes meet. Locked is enough for a single buffer but not for a split or merge, so a design that mixed up those two preconditions would let a locked pair merge or would refuse a locked single buffer. Odd-index merges combined with blocking states check the order of the reason codes, and a design with the wrong priority would report a state fault instead of a pair fault. Splits requested on the odd half, and direction changes on either half of a double, catch designs that touch only one entry of a pair or that classify by the addressed entry alone. Common writes outside the configuration state catch a missing protocol gate.

// File: rtl/mbr_pkg.sv
package mbr_pkg;

  // buffer state codes on buf_state_i (3 is treated as active)
  localparam logic [1:0] ST_DIS     = 2'd0;
  localparam logic [1:0] ST_DIS_LCK = 2'd1;

  typedef enum logic [1:0] {
    CLS_SAME_TYPE = 2'd0,
    CLS_DIR_ONLY  = 2'd1,
    CLS_SPLIT_MRG = 2'd2
  } rc_class_e;

  typedef enum logic [2:0] {
    RSN_OK    = 3'd0,
    RSN_STATE = 3'd1,
    RSN_NA    = 3'd2,
    RSN_PAIR  = 3'd3,
    RSN_PROTO = 3'd4
  } reason_e;

endpackage

// File: rtl/mbr_classify.sv
module mbr_classify
  import mbr_pkg::*;
(
  input  logic       req_common_i,
  input  logic       proto_cfg_i,
  input  logic       idx_odd_i,
  input  logic       req_dir_i,
  input  logic       req_dbl_i,
  input  logic       cur_dir_i,
  input  logic       cur_dbl_i,
  input  logic [1:0] st_self_i,
  input  logic [1:0] st_lo_i,
  input  logic [1:0] st_hi_i,
  output logic       ok_o,
  output reason_e    reason_o,
  output logic       wr_en_o,
  output logic       wr_pair_o,
  output logic       wr_dir_o,
  output logic       wr_dbl_o
);

  rc_class_e cls;
  logic      pair_plain;
  logic      self_free;
  logic      is_merge;

  assign pair_plain = (st_lo_i == ST_DIS) && (st_hi_i == ST_DIS);
  assign self_free  = (st_self_i == ST_DIS) || (st_self_i == ST_DIS_LCK);
  assign is_merge   = !cur_dbl_i;

  always_comb begin
    if (req_dbl_i != cur_dbl_i)      cls = CLS_SPLIT_MRG;
    else if (req_dir_i != cur_dir_i) cls = CLS_DIR_ONLY;
    else                             cls = CLS_SAME_TYPE;
  end

  always_comb begin
    ok_o      = 1'b0;
    reason_o  = RSN_STATE;
    wr_en_o   = 1'b0;
    wr_pair_o = 1'b0;
    wr_dir_o  = req_dir_i;
    wr_dbl_o  = req_dbl_i;
    if (req_common_i) begin
      ok_o     = proto_cfg_i;
      reason_o = proto_cfg_i ? RSN_OK : RSN_PROTO;
    end else begin
      unique case (cls)
        CLS_SPLIT_MRG: begin
          if (is_merge && idx_odd_i) begin
            reason_o = RSN_PAIR;
          end else if (pair_plain) begin
            ok_o      = 1'b1;
            reason_o  = RSN_OK;
            wr_en_o   = 1'b1;
            wr_pair_o = 1'b1;
            wr_dir_o  = is_merge ? 1'b1 : req_dir_i;
          end
        end
        CLS_DIR_ONLY: begin
          if (cur_dbl_i) begin
            reason_o = RSN_NA;
          end else if (self_free) begin
            ok_o     = 1'b1;
            reason_o = RSN_OK;
            wr_en_o  = 1'b1;
          end
        end
        default: begin
          if (cur_dbl_i ? pair_plain : self_free) begin
            ok_o     = 1'b1;
            reason_o = RSN_OK;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/mbr_entry_array.sv
module mbr_entry_array #(
  parameter  int NUM_BUF = 8,
  localparam int IDX_W   = $clog2(NUM_BUF)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic               wr_pair_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic               wr_dir_i,
  input  logic               wr_dbl_i,
  output logic [NUM_BUF-1:0] dir_o,
  output logic [NUM_BUF-1:0] dbl_o
);

  logic [NUM_BUF-1:0] dir_q, dir_d;
  logic [NUM_BUF-1:0] dbl_q, dbl_d;
  logic [NUM_BUF-1:0] hit;

  for (genvar n = 0; n < NUM_BUF; n++) begin : g_ent
    localparam logic [IDX_W-1:0] N_IDX = IDX_W'(n);

    assign hit[n] = wr_en_i &&
                    (wr_pair_i ? (wr_idx_i[IDX_W-1:1] == N_IDX[IDX_W-1:1])
                               : (wr_idx_i == N_IDX));

    always_comb begin
      dir_d[n] = dir_q[n];
      dbl_d[n] = dbl_q[n];
      if (hit[n]) begin
        dir_d[n] = wr_dir_i;
        dbl_d[n] = wr_dbl_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_q[n] <= 1'b0;
        dbl_q[n] <= 1'b0;
      end else if (hit[n]) begin
        dir_q[n] <= dir_d[n];
        dbl_q[n] <= dbl_d[n];
      end
    end

    assert_dbl_is_tx_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      dbl_q[n] |-> dir_q[n]);

    if (n % 2 == 0) begin : g_pair
      assert_pair_type_R11 : assert property (@(posedge clk) disable iff (!rst_n)
        dbl_q[n] == dbl_q[n+1]);
    end
  end

  assign dir_o = dir_q;
  assign dbl_o = dbl_q;

endmodule

// File: rtl/mbr_guard.sv
module mbr_guard
  import mbr_pkg::*;
#(
  parameter  int NUM_BUF = 8,
  parameter  int CFG_W   = 16,
  localparam int IDX_W   = $clog2(NUM_BUF)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 proto_cfg_i,
  input  logic [2*NUM_BUF-1:0] buf_state_i,
  input  logic                 req_valid_i,
  input  logic                 req_common_i,
  input  logic [IDX_W-1:0]     req_idx_i,
  input  logic                 req_dir_i,
  input  logic                 req_dbl_i,
  input  logic [CFG_W-1:0]     req_cfg_i,
  output logic                 rsp_acc_o,
  output logic                 rsp_rej_o,
  output logic [2:0]           rsp_code_o,
  output logic [NUM_BUF-1:0]   buf_dir_o,
  output logic [NUM_BUF-1:0]   buf_dbl_o,
  output logic [CFG_W-1:0]     cfg_o
);

  logic [1:0]       st_a [NUM_BUF];
  logic [IDX_W-1:0] idx_lo, idx_hi;
  logic [1:0]       st_lo, st_hi;
  logic             cls_ok, cls_wr_en, cls_wr_pair, cls_wr_dir, cls_wr_dbl;
  reason_e          cls_reason;
  logic             arr_wr_en;

  logic             acc_q, acc_d, rej_q, rej_d;
  logic [2:0]       code_q, code_d;
  logic [CFG_W-1:0] cfg_q;
  logic             cfg_we;

  for (genvar n = 0; n < NUM_BUF; n++) begin : g_st
    assign st_a[n] = buf_state_i[2*n +: 2];
  end

  assign idx_lo = req_idx_i & ~IDX_W'(1);
  assign idx_hi = req_idx_i |  IDX_W'(1);
  assign st_lo  = st_a[idx_lo];
  assign st_hi  = st_a[idx_hi];

  mbr_classify u_cls (
    .req_common_i (req_common_i),
    .proto_cfg_i  (proto_cfg_i),
    .idx_odd_i    (req_idx_i[0]),
    .req_dir_i    (req_dir_i),
    .req_dbl_i    (req_dbl_i),
    .cur_dir_i    (buf_dir_o[req_idx_i]),
    .cur_dbl_i    (buf_dbl_o[req_idx_i]),
    .st_self_i    (st_a[req_idx_i]),
    .st_lo_i      (st_lo),
    .st_hi_i      (st_hi),
    .ok_o         (cls_ok),
    .reason_o     (cls_reason),
    .wr_en_o      (cls_wr_en),
    .wr_pair_o    (cls_wr_pair),
    .wr_dir_o     (cls_wr_dir),
    .wr_dbl_o     (cls_wr_dbl)
  );

  assign arr_wr_en = req_valid_i && cls_wr_en;

  mbr_entry_array #(.NUM_BUF(NUM_BUF)) u_arr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (arr_wr_en),
    .wr_pair_i (cls_wr_pair),
    .wr_idx_i  (req_idx_i),
    .wr_dir_i  (cls_wr_dir),
    .wr_dbl_i  (cls_wr_dbl),
    .dir_o     (buf_dir_o),
    .dbl_o     (buf_dbl_o)
  );

  // response next state
  always_comb begin
    acc_d  = req_valid_i &&  cls_ok;
    rej_d  = req_valid_i && !cls_ok;
    code_d = req_valid_i ? cls_reason : RSN_OK;
  end

  assign cfg_we = req_valid_i && req_common_i && cls_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      rej_q  <= 1'b0;
      code_q <= 3'd0;
    end else begin
      acc_q  <= acc_d;
      rej_q  <= rej_d;
      code_q <= code_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= req_cfg_i;
  end

  assign rsp_acc_o  = acc_q;
  assign rsp_rej_o  = rej_q;
  assign rsp_code_o = code_q;
  assign cfg_o      = cfg_q;

  assert_one_rsp_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_i |=> (rsp_acc_o ^ rsp_rej_o));

  assert_idle_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid_i |=> !(rsp_acc_o || rsp_rej_o));

  assert_hold_on_reject_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    rsp_rej_o |-> ($stable(buf_dir_o) && $stable(buf_dbl_o) && $stable(cfg_o)));

  assert_cfg_gate_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> $past(req_valid_i && req_common_i && proto_cfg_i));

  assert_pair_plain_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr_en && cls_wr_pair) |-> (st_lo == ST_DIS && st_hi == ST_DIS));

endmodule

// File: tb/mbr_guard_tb_top.sv
`timescale 1ns/1ps
module mbr_guard_tb_top;

  localparam int NB  = 8;
  localparam int IW  = 3;
  localparam int CW  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          proto_cfg = 1'b0;
  logic [2*NB-1:0] buf_state;
  logic          req_valid = 1'b0;
  logic          req_common = 1'b0;
  logic [IW-1:0] req_idx = '0;
  logic          req_dir = 1'b0;
  logic          req_dbl = 1'b0;
  logic [CW-1:0] req_cfg = '0;
  logic          rsp_acc, rsp_rej;
  logic [2:0]    rsp_code;
  logic [NB-1:0] buf_dir, buf_dbl;
  logic [CW-1:0] cfg;

  logic [1:0]    st_m [NB];
  logic [NB-1:0] m_dir, m_dbl;
  logic [CW-1:0] m_cfg;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  always_comb for (int n = 0; n < NB; n++) buf_state[2*n +: 2] = st_m[n];

  mbr_guard #(.NUM_BUF(NB), .CFG_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .proto_cfg_i(proto_cfg), .buf_state_i(buf_state),
    .req_valid_i(req_valid), .req_common_i(req_common), .req_idx_i(req_idx),
    .req_dir_i(req_dir), .req_dbl_i(req_dbl), .req_cfg_i(req_cfg),
    .rsp_acc_o(rsp_acc), .rsp_rej_o(rsp_rej), .rsp_code_o(rsp_code),
    .buf_dir_o(buf_dir), .buf_dbl_o(buf_dbl), .cfg_o(cfg));

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // expected outcome from the requirements
  function automatic void predict(input int idx, input bit rd, input bit rdb, input bit com,
                                  output bit acc, output int code, output string tag);
    int lo, hi;
    bit lo_dis, hi_dis, self_free;
    lo = idx & ~1; hi = lo + 1;
    lo_dis = (st_m[lo] == 0); hi_dis = (st_m[hi] == 0);
    self_free = (st_m[idx] <= 1);
    acc = 0; code = 1;
    if (com) begin
      tag = "R9"; acc = proto_cfg; code = proto_cfg ? 0 : 4;
    end else if (rdb != m_dbl[idx]) begin
      if (!m_dbl[idx] && (idx % 2 == 1)) begin tag = "R7"; code = 3; end
      else begin tag = "R6"; acc = lo_dis && hi_dis; code = acc ? 0 : 1; end
    end else if (rd != m_dir[idx]) begin
      if (m_dbl[idx]) begin tag = "R4"; code = 2; end
      else begin tag = "R3"; acc = self_free; code = acc ? 0 : 1; end
    end else if (m_dbl[idx]) begin
      tag = "R5"; acc = lo_dis && hi_dis; code = acc ? 0 : 1;
    end else begin
      tag = "R3"; acc = self_free; code = acc ? 0 : 1;
    end
  endfunction

  task automatic do_req(input int idx, input bit rd, input bit rdb, input bit com,
                        input logic [CW-1:0] cd);
    bit acc; int code; string tag;
    int lo;
    predict(idx, rd, rdb, com, acc, code, tag);
    req_valid = 1; req_idx = IW'(idx); req_dir = rd; req_dbl = rdb;
    req_common = com; req_cfg = cd;
    @(posedge clk);
    lo = idx & ~1;
    if (acc) begin
      if (com) m_cfg = cd;
      else if (rdb != m_dbl[idx]) begin
        m_dbl[lo] = rdb; m_dbl[lo+1] = rdb;
        m_dir[lo] = rdb ? 1'b1 : rd; m_dir[lo+1] = rdb ? 1'b1 : rd;
      end else m_dir[idx] = rd;
    end
    @(negedge clk);
    check("R2", "accept", rsp_acc, acc);
    check("R2", "reject", rsp_rej, !acc);
    check(tag, "code", rsp_code, code);
    check("R10", "dir", buf_dir, m_dir);
    check("R10", "dbl", buf_dbl, m_dbl);
    check("R11", "dbl tx", longint'(buf_dbl & ~buf_dir), 0);
    check("R9", "cfg", cfg, m_cfg);
    req_valid = 0;
    @(posedge clk); @(negedge clk);
    check("R2", "idle", {rsp_acc, rsp_rej}, 0);
  endtask

  task automatic set_st(input int a, input logic [1:0] v);
    st_m[a] = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int n = 0; n < NB; n++) st_m[n] = 2'd0;
    m_dir = '0; m_dbl = '0; m_cfg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); @(negedge clk);
    // R1 reset state
    check("R1", "dir", buf_dir, 0);
    check("R1", "dbl", buf_dbl, 0);
    check("R1", "cfg", cfg, 0);
    check("R1", "rsp", {rsp_acc, rsp_rej}, 0);

    set_st(1, 2'd1); do_req(1, 1, 0, 0, 0);        // R3 locked single, dir change accepted
    set_st(1, 2'd2); do_req(1, 0, 0, 0, 0);        // R3 active -> state
    set_st(1, 2'd3); do_req(1, 1, 0, 0, 0);        // R3 code 3 active, same type
    set_st(1, 2'd0);
    set_st(3, 2'd2); do_req(3, 1, 1, 0, 0);        // R7 odd merge, pair beats state
    set_st(3, 2'd1); do_req(2, 1, 1, 0, 0);        // R6 locked not enough
    set_st(3, 2'd0); do_req(2, 0, 1, 0, 0);        // R7 merge, forced tx, R10 both entries
    set_st(2, 2'd0); do_req(3, 0, 1, 0, 0);        // R4 direction change on double
    do_req(2, 0, 1, 0, 0);                         // R4 on commit half
    set_st(3, 2'd1); do_req(2, 1, 1, 0, 0);        // R5 one half locked
    set_st(3, 2'd0); do_req(3, 1, 1, 0, 0);        // R5 both disabled
    set_st(2, 2'd1); do_req(3, 0, 0, 0, 0);        // R6 split blocked by lock
    set_st(2, 2'd0); do_req(3, 0, 0, 0, 0);        // R8 split on odd half, both rx
    proto_cfg = 0;   do_req(0, 0, 0, 1, 16'hBEEF); // R9 blocked
    proto_cfg = 1;   do_req(5, 1, 1, 1, 16'h1234); // R9 stored, entries untouched

    for (int k = 0; k < 600; k++) begin
      for (int n = 0; n < NB; n++) begin
        int r;
        r = int'($urandom_range(0, 9));
        st_m[n] = (r < 6) ? 2'd0 : 2'(r - 6);
      end
      proto_cfg = $urandom_range(0, 1);
      do_req(int'($urandom_range(0, NB-1)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), ($urandom_range(0, 7) == 0),
             CW'($urandom));
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule